// File: doc/BRIEF.md
# Per-Core Slowdown and Interferer Estimator

This block watches a memory controller shared by several cores and, once per fixed-length interval, estimates how much each core has been slowed by the others. Each core runs a count of cycles it spent executing in shared mode and a count of extra cycles lost to other cores. From these the block derives an alone-run estimate (shared cycles minus excess cycles) and a slowdown ratio (shared cycles over the alone-run estimate). The controller reports two kinds of loss. The first is a per-cycle interference bit per core that names the core that caused the loss. The second is a stream of bank accesses, each tagged with a core id. For the bank accesses the block keeps, per core and bank, the row that core would have open if it ran by itself. An access that misses the real open row but hits that private row is charged a fixed penalty, and the penalty is billed to the core that opened the current row.

At each interval end the block reports four results. The first is a flag raised when the ratio of the largest slowdown to the smallest slowdown exceeds a programmable fixed-point target. The second is the core with the highest slowdown. The third is the core that caused that core the most excess cycles. The fourth is a one-cycle strobe that marks the results as new. A throttling unit downstream uses these results to slow the culprit core and speed up the victim core. All ratio comparisons use cross-multiplication, so the block contains no divider.

Top module: `unfair_estimator`

## Requirements
- R1: While reset is held, and until the first result, `resValid`, `unfairHigh`, `slowCore` and `culpritCore` are all 0.
- R2: `resValid` is high for exactly one cycle in every INTERVAL_LEN cycles. It first goes high in cycle INTERVAL_LEN, where cycle 0 is the first rising edge after reset is released.
- R3: A core's shared count rises by one on each cycle its `coreActive` bit is set. Its slowdown is shared/(shared − excess). When excess is equal to or greater than shared (an alone estimate of zero), that core's slowdown is taken as exactly 1.
- R4: On each cycle that `intfBit[i]` is set, core i's excess count rises by 1. If the 2-bit field `intfSrc[2i+1:2i]` names a core j ≠ i, the pair count (i, j) also rises by 1. A field that names i itself adds nothing to any pair count.
- R5: Each access (`accValid`) is compared with the real open row of its bank and with the issuing core's private row for that bank. When the bank has an open row that differs from the access row, and the core's private row equals the access row, CONFLICT_PENALTY is added to that core's excess count and to its pair count against the core that opened the current row. Every access then becomes the bank's open row and that core's private row.
- R6: `slowCore` is the core with the highest slowdown. On a tie the lowest index wins.
- R7: `culpritCore` is the core j ≠ `slowCore` with the largest pair count (`slowCore`, j). On a tie the lowest such j wins, including when all counts are zero.
- R8: `unfairHigh` is 1 exactly when the largest slowdown divided by the smallest slowdown is strictly greater than `unfairTarget`/2^TGT_FRAC (TGT_FRAC = 4, so 16 means 1.0).
- R9: Results are taken from the events of the INTERVAL_LEN cycles that end just before the evaluation cycle. The evaluation cycle's own events count toward the next interval. Row state and private rows carry across interval ends.
- R10: Between strobes, `unfairHigh`, `slowCore` and `culpritCore` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| coreActive | input | N_CORES | Core i ran in shared mode this cycle |
| intfBit | input | N_CORES | Core i lost this cycle to interference |
| intfSrc | input | N_CORES*IDW | Per core, the id of the core causing that cycle's loss |
| accValid | input | 1 | A bank access occurs this cycle |
| accCore | input | IDW | Core issuing the access |
| accBank | input | BW | Bank accessed |
| accRow | input | ROW_W | Row accessed |
| unfairTarget | input | TGT_W | Unfairness target, fixed point with TGT_FRAC fraction bits |
| unfairHigh | output | 1 | Estimated unfairness exceeded the target |
| slowCore | output | IDW | Core with the highest slowdown |
| culpritCore | output | IDW | Core that interfered most with `slowCore` |
| resValid | output | 1 | One-cycle strobe: results updated |

## Verification
The interval counter is 0 on the first edge after reset. The evaluation cycle is therefore every cycle whose index modulo INTERVAL_LEN equals INTERVAL_LEN−1. The three results are registered at the end of that cycle and are read in the next cycle, together with `resValid`. The bench drives stimulus and samples outputs at the falling edge. It keeps its own cycle index, and at the input of each evaluation cycle it computes the expected results from an arithmetic model of the counters, then clears the model before adding that cycle's events. That expectation is compared exactly one cycle later. On every other cycle the bench checks that the strobe is low and that the outputs hold.

// File: rtl/ufe_pkg.sv
package ufe_pkg;

  // Strobes from the interval control to the datapath.
  typedef struct packed {
    logic evalStb;  // latch the results from the current counter values
    logic clrStb;   // restart every counter from this cycle's increment
  } ufeCtl_t;

endpackage

// File: rtl/ufe_ctrl.sv
module ufe_ctrl
  import ufe_pkg::*;
#(
  parameter int INTERVAL_LEN = 64
) (
  input  logic    clk,
  input  logic    rstN,
  output ufeCtl_t ctl
);

  localparam int IVW = (INTERVAL_LEN > 2) ? $clog2(INTERVAL_LEN) : 1;
  localparam logic [IVW-1:0] LAST = IVW'(INTERVAL_LEN - 1);

  logic [IVW-1:0] ivCnt;
  logic           atEnd;

  assign atEnd = (ivCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      ivCnt <= '0;
    else if (atEnd) ivCnt <= '0;
    else            ivCnt <= ivCnt + IVW'(1);
  end

  always_comb begin
    ctl.evalStb = atEnd;
    ctl.clrStb  = atEnd;
  end

endmodule

// File: rtl/ufe_row_track.sv
module ufe_row_track #(
  parameter int N_CORES = 4,
  parameter int N_BANKS = 4,
  parameter int ROW_W   = 8,
  parameter int IDW     = $clog2(N_CORES),
  parameter int BW      = $clog2(N_BANKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  input  logic [IDW-1:0]   accCore,
  input  logic [BW-1:0]    accBank,
  input  logic [ROW_W-1:0] accRow,
  output logic             chargeValid,
  output logic [IDW-1:0]   chargeOwner
);

  localparam int SLOTS = N_CORES * N_BANKS;
  localparam int SW    = $clog2(SLOTS);

  // Real bank state: open row and the core that opened it.
  logic [N_BANKS-1:0] openValid;
  logic [ROW_W-1:0]   openRow   [N_BANKS];
  logic [IDW-1:0]     openOwner [N_BANKS];
  // Private rows: the row each core would have open in each bank when running alone.
  logic [SLOTS-1:0]   shadowValid;
  logic [ROW_W-1:0]   shadowRow [SLOTS];

  logic [SW-1:0] slot;
  logic          realHit, shadowHit;

  assign slot      = SW'(accCore) * SW'(N_BANKS) + SW'(accBank);
  assign realHit   = openValid[accBank] && (openRow[accBank] == accRow);
  assign shadowHit = shadowValid[slot] && (shadowRow[slot] == accRow);

  assign chargeValid = accValid && openValid[accBank] && !realHit && shadowHit;
  assign chargeOwner = openOwner[accBank];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      openValid   <= '0;
      shadowValid <= '0;
      for (int b = 0; b < N_BANKS; b++) begin
        openRow[b]   <= '0;
        openOwner[b] <= '0;
      end
      for (int s = 0; s < SLOTS; s++) shadowRow[s] <= '0;
    end else if (accValid) begin
      openValid[accBank]  <= 1'b1;
      openRow[accBank]    <= accRow;
      openOwner[accBank]  <= accCore;
      shadowValid[slot]   <= 1'b1;
      shadowRow[slot]     <= accRow;
    end
  end

endmodule

// File: rtl/ufe_eval.sv
module ufe_eval #(
  parameter int N_CORES  = 4,
  parameter int CNT_W    = 12,
  parameter int TGT_W    = 8,
  parameter int TGT_FRAC = 4,
  parameter int IDW      = $clog2(N_CORES)
) (
  input  logic [CNT_W-1:0] sharedCnt [N_CORES],
  input  logic [CNT_W-1:0] excessCnt [N_CORES],
  input  logic [CNT_W-1:0] pairCnt   [N_CORES][N_CORES],
  input  logic [TGT_W-1:0] target,
  output logic             unfair,
  output logic [IDW-1:0]   slowIdx,
  output logic [IDW-1:0]   culpritIdx
);

  localparam int PW = 2 * CNT_W + TGT_W + TGT_FRAC;

  logic [CNT_W-1:0] tq [N_CORES];
  logic [CNT_W-1:0] aq [N_CORES];
  logic [CNT_W-1:0] victimRow [N_CORES];
  logic [IDW-1:0]   maxSel, minSel, cSel;
  logic [PW-1:0]    lhs, rhs;

  function automatic logic [PW-1:0] mulw(input logic [CNT_W-1:0] x, input logic [CNT_W-1:0] y);
    return PW'(x) * PW'(y);
  endfunction

  // Slowdown as the fraction tq/aq; a zero alone estimate becomes 1/1.
  always_comb begin
    for (int i = 0; i < N_CORES; i++) begin
      if (sharedCnt[i] > excessCnt[i]) begin
        tq[i] = sharedCnt[i];
        aq[i] = sharedCnt[i] - excessCnt[i];
      end else begin
        tq[i] = CNT_W'(1);
        aq[i] = CNT_W'(1);
      end
    end
  end

  // Largest and smallest slowdown by cross-multiplication, lowest index on ties.
  always_comb begin
    maxSel = '0;
    minSel = '0;
    for (int i = 1; i < N_CORES; i++) begin
      if (mulw(tq[i], aq[maxSel]) > mulw(tq[maxSel], aq[i])) maxSel = IDW'(i);
      if (mulw(tq[i], aq[minSel]) < mulw(tq[minSel], aq[i])) minSel = IDW'(i);
    end
  end

  // maxS / minS > target / 2^FRAC  <=>  tMax*aMin*2^FRAC > target*tMin*aMax
  assign lhs    = mulw(tq[maxSel], aq[minSel]) << TGT_FRAC;
  assign rhs    = mulw(tq[minSel], aq[maxSel]) * PW'(target);
  assign unfair = (lhs > rhs);

  assign victimRow = pairCnt[maxSel];

  always_comb begin
    cSel = (maxSel == '0) ? IDW'(1) : '0;
    for (int j = 0; j < N_CORES; j++) begin
      if ((IDW'(j) != maxSel) && (victimRow[j] > victimRow[cSel])) cSel = IDW'(j);
    end
  end

  assign slowIdx    = maxSel;
  assign culpritIdx = cSel;

endmodule

// File: rtl/ufe_datapath.sv
module ufe_datapath
  import ufe_pkg::*;
#(
  parameter int N_CORES          = 4,
  parameter int N_BANKS          = 4,
  parameter int ROW_W            = 8,
  parameter int CNT_W            = 12,
  parameter int TGT_W            = 8,
  parameter int TGT_FRAC         = 4,
  parameter int CONFLICT_PENALTY = 8,
  parameter int IDW              = $clog2(N_CORES),
  parameter int BW               = $clog2(N_BANKS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ufeCtl_t                ctl,
  input  logic [N_CORES-1:0]     coreActive,
  input  logic [N_CORES-1:0]     intfBit,
  input  logic [N_CORES*IDW-1:0] intfSrc,
  input  logic                   accValid,
  input  logic [IDW-1:0]         accCore,
  input  logic [BW-1:0]          accBank,
  input  logic [ROW_W-1:0]       accRow,
  input  logic [TGT_W-1:0]       unfairTarget,
  output logic                   unfairHigh,
  output logic [IDW-1:0]         slowCore,
  output logic [IDW-1:0]         culpritCore,
  output logic                   resValid
);

  localparam logic [CNT_W-1:0] PEN = CNT_W'(CONFLICT_PENALTY);

  logic [CNT_W-1:0] sharedCnt [N_CORES];
  logic [CNT_W-1:0] excessCnt [N_CORES];
  logic [CNT_W-1:0] pairCnt   [N_CORES][N_CORES];
  logic             chargeValid;
  logic [IDW-1:0]   chargeOwner;
  logic             evUnfair;
  logic [IDW-1:0]   evSlow, evCulprit;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] base, input logic [CNT_W-1:0] inc);
    logic [CNT_W:0] s;
    s = {1'b0, base} + {1'b0, inc};
    return s[CNT_W] ? '1 : s[CNT_W-1:0];
  endfunction

  ufe_row_track #(
    .N_CORES(N_CORES), .N_BANKS(N_BANKS), .ROW_W(ROW_W), .IDW(IDW), .BW(BW)
  ) uRows (
    .clk(clk), .rstN(rstN),
    .accValid(accValid), .accCore(accCore), .accBank(accBank), .accRow(accRow),
    .chargeValid(chargeValid), .chargeOwner(chargeOwner)
  );

  for (genvar i = 0; i < N_CORES; i++) begin : gCore
    logic             victimHere;
    logic [CNT_W-1:0] shReg, exReg, exInc;

    assign victimHere = chargeValid && (accCore == IDW'(i));
    assign exInc = (intfBit[i] ? CNT_W'(1) : '0) + (victimHere ? PEN : '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shReg <= '0;
        exReg <= '0;
      end else begin
        shReg <= bump(ctl.clrStb ? '0 : shReg, CNT_W'(coreActive[i]));
        exReg <= bump(ctl.clrStb ? '0 : exReg, exInc);
      end
    end

    assign sharedCnt[i] = shReg;
    assign excessCnt[i] = exReg;

    for (genvar j = 0; j < N_CORES; j++) begin : gPair
      if (j != i) begin : gOff
        logic [CNT_W-1:0] pReg, pInc;
        assign pInc = ((intfBit[i] && (intfSrc[i*IDW +: IDW] == IDW'(j))) ? CNT_W'(1) : '0)
                    + ((victimHere && (chargeOwner == IDW'(j))) ? PEN : '0);
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) pReg <= '0;
          else       pReg <= bump(ctl.clrStb ? '0 : pReg, pInc);
        end
        assign pairCnt[i][j] = pReg;
      end else begin : gDiag
        assign pairCnt[i][j] = '0;
      end
    end
  end

  ufe_eval #(
    .N_CORES(N_CORES), .CNT_W(CNT_W), .TGT_W(TGT_W), .TGT_FRAC(TGT_FRAC), .IDW(IDW)
  ) uEval (
    .sharedCnt(sharedCnt), .excessCnt(excessCnt), .pairCnt(pairCnt),
    .target(unfairTarget),
    .unfair(evUnfair), .slowIdx(evSlow), .culpritIdx(evCulprit)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unfairHigh  <= 1'b0;
      slowCore    <= '0;
      culpritCore <= '0;
      resValid    <= 1'b0;
    end else begin
      resValid <= ctl.evalStb;
      if (ctl.evalStb) begin
        unfairHigh  <= evUnfair;
        slowCore    <= evSlow;
        culpritCore <= evCulprit;
      end
    end
  end

endmodule

// File: rtl/unfair_estimator.sv
module unfair_estimator
  import ufe_pkg::*;
#(
  parameter int N_CORES          = 4,
  parameter int N_BANKS          = 4,
  parameter int ROW_W            = 8,
  parameter int CNT_W            = 12,
  parameter int TGT_W            = 8,
  parameter int TGT_FRAC         = 4,
  parameter int INTERVAL_LEN     = 64,
  parameter int CONFLICT_PENALTY = 8
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [N_CORES-1:0]                   coreActive,
  input  logic [N_CORES-1:0]                   intfBit,
  input  logic [N_CORES*$clog2(N_CORES)-1:0]   intfSrc,
  input  logic                                 accValid,
  input  logic [$clog2(N_CORES)-1:0]           accCore,
  input  logic [$clog2(N_BANKS)-1:0]           accBank,
  input  logic [ROW_W-1:0]                     accRow,
  input  logic [TGT_W-1:0]                     unfairTarget,
  output logic                                 unfairHigh,
  output logic [$clog2(N_CORES)-1:0]           slowCore,
  output logic [$clog2(N_CORES)-1:0]           culpritCore,
  output logic                                 resValid
);

  localparam int IDW = $clog2(N_CORES);
  localparam int BW  = $clog2(N_BANKS);

  ufeCtl_t ctl;

  ufe_ctrl #(.INTERVAL_LEN(INTERVAL_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .ctl(ctl)
  );

  ufe_datapath #(
    .N_CORES(N_CORES), .N_BANKS(N_BANKS), .ROW_W(ROW_W), .CNT_W(CNT_W),
    .TGT_W(TGT_W), .TGT_FRAC(TGT_FRAC), .CONFLICT_PENALTY(CONFLICT_PENALTY),
    .IDW(IDW), .BW(BW)
  ) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .coreActive(coreActive), .intfBit(intfBit), .intfSrc(intfSrc),
    .accValid(accValid), .accCore(accCore), .accBank(accBank), .accRow(accRow),
    .unfairTarget(unfairTarget),
    .unfairHigh(unfairHigh), .slowCore(slowCore), .culpritCore(culpritCore),
    .resValid(resValid)
  );

endmodule

// File: rtl/unfair_estimator_chk.sv
module unfair_estimator_chk
  import ufe_pkg::*;
#(
  parameter int N_CORES      = 4,
  parameter int INTERVAL_LEN = 64
) (
  input logic                       clk,
  input logic                       rstN,
  input ufeCtl_t                    ctl,
  input logic                       resValid,
  input logic                       unfairHigh,
  input logic [$clog2(N_CORES)-1:0] slowCore,
  input logic [$clog2(N_CORES)-1:0] culpritCore
);

  localparam int GW = $clog2(INTERVAL_LEN + 1) + 1;
  localparam logic [GW-1:0] GMAX = '1;

  // Cycles since reset release or since the last strobe.
  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         gap <= '0;
    else if (resValid) gap <= GW'(1);
    else if (gap != GMAX) gap <= gap + GW'(1);
  end

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  a_r2_period: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (gap == GW'(INTERVAL_LEN)));

  a_r9_eval_to_strobe: assert property (@(posedge clk) disable iff (!rstN)
    ctl.evalStb |=> resValid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> $stable({unfairHigh, slowCore, culpritCore}));

  a_r7_culprit_differs: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (culpritCore != slowCore));

endmodule

bind unfair_estimator unfair_estimator_chk #(
  .N_CORES(N_CORES), .INTERVAL_LEN(INTERVAL_LEN)
) uChk (
  .clk(clk), .rstN(rstN), .ctl(ctl), .resValid(resValid),
  .unfairHigh(unfairHigh), .slowCore(slowCore), .culpritCore(culpritCore)
);

// File: tb/unfair_estimator_test.sv
module unfair_estimator_test;

  localparam int NC  = 4;
  localparam int L   = 32;
  localparam int PEN = 8;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] coreActive, intfBit;
  logic [7:0] intfSrc;
  logic       accValid;
  logic [1:0] accCore, accBank;
  logic [7:0] accRow;
  logic [7:0] unfairTarget;
  logic       unfairHigh, resValid;
  logic [1:0] slowCore, culpritCore;

  always #5 clk = ~clk;

  unfair_estimator #(
    .N_CORES(4), .N_BANKS(4), .ROW_W(8), .CNT_W(12), .TGT_W(8), .TGT_FRAC(4),
    .INTERVAL_LEN(L), .CONFLICT_PENALTY(PEN)
  ) uut (
    .clk(clk), .rstN(rstN), .coreActive(coreActive), .intfBit(intfBit), .intfSrc(intfSrc),
    .accValid(accValid), .accCore(accCore), .accBank(accBank), .accRow(accRow),
    .unfairTarget(unfairTarget), .unfairHigh(unfairHigh), .slowCore(slowCore),
    .culpritCore(culpritCore), .resValid(resValid)
  );

  int    errors = 0;
  int    checks = 0;
  int    k = 0;
  string scen = "R1 reset";

  longint T[NC], E[NC], P[NC][NC];
  bit     openV[4];
  int     openRow[4], openOwn[4];
  bit     shV[NC][4];
  int     shRow[NC][4];
  bit     pendU, heldU;
  int     pendS, pendC, heldS, heldC;
  bit [31:0] lfsr = 32'h1234_5678;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] cycle=%0d actual=%0d expected=%0d", req, scen, k, act, exp);
    end
  endtask

  function automatic bit [31:0] nextRand();
    lfsr ^= lfsr << 13;
    lfsr ^= lfsr >> 17;
    lfsr ^= lfsr << 5;
    return lfsr;
  endfunction

  // Expected results from the model counters (R3, R6, R7, R8).
  task automatic evaluate();
    longint t[NC], a[NC];
    int mx, mn, c;
    for (int i = 0; i < NC; i++) begin
      if (T[i] > E[i]) begin t[i] = T[i]; a[i] = T[i] - E[i]; end
      else begin t[i] = 1; a[i] = 1; end
    end
    mx = 0; mn = 0;
    for (int i = 1; i < NC; i++) begin
      if (t[i] * a[mx] > t[mx] * a[i]) mx = i;
      if (t[i] * a[mn] < t[mn] * a[i]) mn = i;
    end
    pendU = (t[mx] * a[mn] * 16 > longint'(unfairTarget) * t[mn] * a[mx]);
    pendS = mx;
    c = -1;
    for (int j = 0; j < NC; j++)
      if (j != mx && (c < 0 || P[mx][j] > P[mx][c])) c = j;
    pendC = c;
  endtask

  task automatic step(input logic [3:0] act, input logic [3:0] intf, input logic [7:0] src,
                      input bit av, input int ac, input int ab, input int ar);
    bit ev;
    logic [4:0] expv;
    ev = (k > 0) && (k % L == 0);
    check("R2 strobe", resValid, ev);
    if (ev) begin
      check("R8 unfair flag", unfairHigh, pendU);
      check("R6 slowest core", slowCore, pendS);
      check("R7 culprit core", culpritCore, pendC);
      heldU = pendU; heldS = pendS; heldC = pendC;
    end else begin
      expv = {heldU, 2'(heldS), 2'(heldC)};
      check("R10 outputs held", {unfairHigh, slowCore, culpritCore}, expv);
    end
    coreActive = act; intfBit = intf; intfSrc = src;
    accValid = av; accCore = 2'(ac); accBank = 2'(ab); accRow = 8'(ar);
    // R9: the evaluation cycle's own events start the next interval
    if (k % L == L - 1) begin
      evaluate();
      for (int i = 0; i < NC; i++) begin
        T[i] = 0; E[i] = 0;
        for (int j = 0; j < NC; j++) P[i][j] = 0;
      end
    end
    for (int i = 0; i < NC; i++) begin
      if (act[i]) T[i]++;
      if (intf[i]) begin
        int s;
        E[i]++;
        s = int'(src[i*2 +: 2]);
        if (s != i) P[i][s]++;
      end
    end
    if (av) begin
      bit realHit, shHit;
      realHit = openV[ab] && openRow[ab] == ar;
      shHit   = shV[ac][ab] && shRow[ac][ab] == ar;
      if (openV[ab] && !realHit && shHit) begin
        E[ac] += PEN;
        P[ac][openOwn[ab]] += PEN;
      end
      openV[ab] = 1; openRow[ab] = ar; openOwn[ab] = ac;
      shV[ac][ab] = 1; shRow[ac][ab] = ar;
    end
    k++;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) begin
      T[i] = 0; E[i] = 0;
      for (int j = 0; j < NC; j++) begin P[i][j] = 0; shV[i][j] = 0; shRow[i][j] = 0; end
    end
    for (int b = 0; b < 4; b++) begin openV[b] = 0; openRow[b] = 0; openOwn[b] = 0; end
    heldU = 0; heldS = 0; heldC = 0;
    rstN = 1'b0; coreActive = '0; intfBit = '0; intfSrc = '0;
    accValid = 1'b0; accCore = '0; accBank = '0; accRow = '0; unfairTarget = 8'd16;
    repeat (3) @(negedge clk);
    check("R1 reset strobe", resValid, 0);
    check("R1 reset flag", unfairHigh, 0);
    check("R1 reset slow", slowCore, 0);
    check("R1 reset culprit", culpritCore, 0);
    rstN = 1'b1;

    // Interval 0: no activity, every slowdown is 1.
    scen = "R3 idle interval";
    repeat (L) step(4'h0, 4'h0, 8'h00, 0, 0, 0, 0);

    // Interval 1: core 2 hit by core 3 for 20 cycles, core 1 by core 0 for 5.
    scen = "R4 interference bits";
    for (int c = 0; c < L; c++)
      step(4'hF, {1'b0, c < 20, c < 5, 1'b0}, 8'b00_11_00_00, 0, 0, 0, 0);

    // Interval 2: same load, target high enough to suppress the flag.
    scen = "R8 high target";
    unfairTarget = 8'd255;
    for (int c = 0; c < L; c++)
      step(4'hF, {1'b0, c < 20, c < 5, 1'b0}, 8'b00_11_00_00, 0, 0, 0, 0);

    // Interval 3: row conflicts that hit private rows.
    scen = "R5 row conflicts";
    unfairTarget = 8'd16;
    for (int c = 0; c < L; c++) begin
      case (c)
        0, 2, 4: step(4'hF, 4'h0, 8'h00, 1, 0, 1, 5);
        1:       step(4'hF, 4'h0, 8'h00, 1, 1, 1, 7);
        3:       step(4'hF, 4'h0, 8'h00, 1, 3, 1, 9);
        5:       step(4'hF, 4'h0, 8'h00, 1, 1, 2, 1);
        default: step(4'hF, 4'h0, 8'h00, 0, 0, 0, 0);
      endcase
    end

    // Interval 4: only the evaluation cycle carries an event.
    scen = "R9 boundary event";
    for (int c = 0; c < L; c++) begin
      if (c == L - 1) step(4'hF, 4'b0010, 8'b00_00_10_00, 0, 0, 0, 0);
      else            step(4'h0, 4'h0, 8'h00, 0, 0, 0, 0);
    end
    scen = "R9 carried event";
    repeat (L) step(4'hF, 4'h0, 8'h00, 0, 0, 0, 0);

    // Mixed pseudo-random intervals with varying targets.
    scen = "R6 R7 R8 random mix";
    for (int n = 0; n < 40; n++) begin
      bit [31:0] r0;
      r0 = nextRand();
      unfairTarget = 8'(8 + (r0 % 40));
      for (int c = 0; c < L; c++) begin
        bit [31:0] r1, r2;
        r1 = nextRand();
        r2 = nextRand();
        step(r1[3:0] | r1[7:4], r1[11:8] & r1[15:12] & {4{r0[n % 8]}}, r1[25:18],
             r2[0], int'(r2[2:1]), int'(r2[4:3]), int'(r2[6:5]));
      end
    end

    scen = "R2 final strobe";
    step(4'h0, 4'h0, 8'h00, 0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule